// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address. It uses a fixed arithmetic mapping and no translation table. Four 16-bit base registers hold the start of the code, data, stack and extra segments. The register is picked from the kind of access requested: an instruction fetch uses the code base, a data access uses the data base, and a stack access uses the stack base. An override can name any of the four registers instead. The chosen base is moved up by four bit positions and the offset is added to it. Any carry out of the top address bit is dropped, so the address space wraps at 1 MB.

Software or a sequencer loads the bases through a simple write port. Each request produces a registered address one clock later, and a valid flag marks it. Bases may be set so that segments overlap or coincide in physical memory. The mapping adds no memory cycles of its own.

Top module: `seg_phys_addr_gen`

## Requirements
- R1: While reset is held, and right after it, the code base is 0xFFFF and the data, stack and extra bases are 0x0000. `pa_valid` is 0 and `pa_addr` is 0.
- R2: The physical address equals (base × 16 + offset) taken modulo 2^20, where base is the selected 16-bit register.
- R3: With `ovr_valid` low, `req_kind` selects the base as follows: 2'b00 (fetch) uses code, 2'b01 (data) uses data, 2'b10 (stack) uses stack, and 2'b11 is treated as a data access.
- R4: With `ovr_valid` high, `ovr_sel` names the base whatever the kind: 2'b00 extra, 2'b01 code, 2'b10 stack, 2'b11 data.
- R5: With `ovr_valid` low, the value of `ovr_sel` has no effect on the address.
- R6: A write (`wr_en` high) loads `wr_base` into the register named by `wr_sel`, using the same encoding as R4. Requests from the next cycle onward see the new value. A request in the same cycle as the write uses the old value.
- R7: `pa_valid` equals the `req_valid` of the previous cycle. `pa_addr` keeps its value through cycles with no request.
- R8: A sum that carries past bit 19 wraps around; for example, base 0xFFFF with offset 0x0010 gives 0x00000.
- R9: Two segments with equal bases give the same physical address for the same offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Load a base register this cycle |
| wr_sel | input | 2 | Register to load (00 extra, 01 code, 10 stack, 11 data) |
| wr_base | input | 16 | New base value |
| req_valid | input | 1 | Address request present |
| req_kind | input | 2 | Access kind (00 fetch, 01 data, 10 stack, 11 data) |
| req_off | input | 16 | Offset within the segment |
| ovr_valid | input | 1 | Use `ovr_sel` instead of the implicit choice |
| ovr_sel | input | 2 | Overriding register (00 extra, 01 code, 10 stack, 11 data) |
| pa_valid | output | 1 | Physical address valid |
| pa_addr | output | 20 | Registered physical address |

## Verification
The address and its valid flag for a request are due exactly one rising edge after the request is presented. A base write changes the result of requests presented from the next cycle onward. The bench sets inputs on the falling edge and reads the outputs at the following falling edge, after the single register has updated. Its reference model of the bases is updated only after the expected address for that cycle is computed, so a request that coincides with a write is checked against the old base. Idle cycles are checked the same way: one edge later, valid must be low and the address must be unchanged.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

   // segment register identifiers (override and write encoding)
   typedef enum logic [1:0] {
      SEG_EXTRA = 2'b00,
      SEG_CODE  = 2'b01,
      SEG_STACK = 2'b10,
      SEG_DATA  = 2'b11
   } seg_id_t;

   // kinds of access for the implicit choice
   typedef enum logic [1:0] {
      ACC_FETCH    = 2'b00,
      ACC_DATA     = 2'b01,
      ACC_STACK    = 2'b10,
      ACC_DATA_ALT = 2'b11
   } acc_kind_t;

   localparam int NUM_SEG = 4;

endpackage

// File: rtl/seg_base_bank.sv
module seg_base_bank
   import seg_addr_pkg::*;
#(
   parameter int SEG_W = 16,
   parameter logic [SEG_W-1:0] CODE_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [SEG_W-1:0] wr_base,
   input  logic [1:0]       rd_sel,
   output logic [SEG_W-1:0] rd_base
);

   logic [NUM_SEG-1:0][SEG_W-1:0] bases_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SEG; i++) begin
            bases_q[i] <= (i == int'(SEG_CODE)) ? CODE_RST : '0;
         end
      end else if (wr_en) begin
         bases_q[wr_sel] <= wr_base;
      end
   end

   assign rd_base = bases_q[rd_sel];

   // R6
   base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> bases_q[$past(wr_sel)] == $past(wr_base));

   // R6
   base_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(bases_q));

endmodule

// File: rtl/seg_route.sv
module seg_route
   import seg_addr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] req_kind,
   input  logic       ovr_valid,
   input  logic [1:0] ovr_sel,
   output logic [1:0] seg_pick
);

   seg_id_t implicit_id;

   always_comb begin
      unique case (acc_kind_t'(req_kind))
         ACC_FETCH: implicit_id = SEG_CODE;
         ACC_STACK: implicit_id = SEG_STACK;
         default:   implicit_id = SEG_DATA;
      endcase
   end

   assign seg_pick = ovr_valid ? ovr_sel : implicit_id;

   // R3
   fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_valid && req_kind == 2'b00) |-> seg_pick == 2'b01);

   // R3
   stack_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_valid && req_kind == 2'b10) |-> seg_pick == 2'b10);

   // R4
   override_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_valid |-> seg_pick == ovr_sel);

   // R5
   no_extra_implicit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr_valid |-> seg_pick != 2'b00);

endmodule

// File: rtl/seg_addr_fold.sv
module seg_addr_fold #(
   parameter int SEG_W = 16,
   parameter int OFF_W = 16,
   parameter int SHIFT = 4,
   localparam int PA_W = SEG_W + SHIFT
) (
   input  logic [SEG_W-1:0] base,
   input  logic [OFF_W-1:0] off,
   output logic [PA_W-1:0]  pa
);

   logic [PA_W-1:0] base_ext;
   logic [PA_W-1:0] off_ext;

   assign base_ext = {base, {SHIFT{1'b0}}};

   generate
      if (PA_W > OFF_W) begin : g_widen
         assign off_ext = {{(PA_W-OFF_W){1'b0}}, off};
      end else begin : g_same
         assign off_ext = off;
      end
   endgenerate

   // carry out of the top bit is dropped by width
   assign pa = base_ext + off_ext;

endmodule

// File: rtl/seg_phys_addr_gen.sv
module seg_phys_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int SEG_W = 16,
   parameter int OFF_W = 16,
   parameter int SHIFT = 4,
   parameter logic [SEG_W-1:0] CODE_RST = '1,
   localparam int PA_W = SEG_W + SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [SEG_W-1:0] wr_base,
   input  logic             req_valid,
   input  logic [1:0]       req_kind,
   input  logic [OFF_W-1:0] req_off,
   input  logic             ovr_valid,
   input  logic [1:0]       ovr_sel,
   output logic             pa_valid,
   output logic [PA_W-1:0]  pa_addr
);

   generate
      if (SHIFT < 1 || SHIFT > SEG_W) begin : g_bad_shift
         $error("seg_phys_addr_gen: SHIFT out of range");
      end
      if (PA_W < OFF_W) begin : g_bad_off
         $error("seg_phys_addr_gen: offset wider than address");
      end
   endgenerate

   logic [1:0]       seg_pick;
   logic [SEG_W-1:0] sel_base;
   logic [PA_W-1:0]  pa_next;

   seg_route u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_kind  (req_kind),
      .ovr_valid (ovr_valid),
      .ovr_sel   (ovr_sel),
      .seg_pick  (seg_pick)
   );

   seg_base_bank #(.SEG_W(SEG_W), .CODE_RST(CODE_RST)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_base (wr_base),
      .rd_sel  (seg_pick),
      .rd_base (sel_base)
   );

   seg_addr_fold #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_fold (
      .base (sel_base),
      .off  (req_off),
      .pa   (pa_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa_valid <= 1'b0;
         pa_addr  <= '0;
      end else begin
         pa_valid <= req_valid;
         if (req_valid) begin
            pa_addr <= pa_next;
         end
      end
   end

   // R7
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> pa_valid);

   // R7
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !pa_valid);

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(pa_addr));

   // R2
   low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> pa_addr[SHIFT-1:0] == $past(req_off[SHIFT-1:0]));

endmodule

// File: tb/seg_phys_addr_gen_tb.sv
module seg_phys_addr_gen_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [15:0] wr_base = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic [15:0] req_off = '0;
   logic        ovr_valid = 1'b0;
   logic [1:0]  ovr_sel = '0;
   logic        pa_valid;
   logic [19:0] pa_addr;

   int checks = 0;
   int errors = 0;
   logic [15:0] model_base [4];
   logic [19:0] last_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_phys_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_base(wr_base), .req_valid(req_valid), .req_kind(req_kind),
      .req_off(req_off), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
      .pa_valid(pa_valid), .pa_addr(pa_addr)
   );

   function automatic logic [1:0] exp_seg(logic [1:0] kind, logic ov, logic [1:0] sel);
      if (ov) return sel;
      case (kind)
         2'b00:   return 2'b01;
         2'b10:   return 2'b10;
         default: return 2'b11;
      endcase
   endfunction

   function automatic logic [19:0] exp_pa(logic [15:0] base, logic [15:0] off);
      logic [31:0] s;
      s = ({16'd0, base} << 4) + {16'd0, off};
      return s[19:0];
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
      end
   endtask

   // one request cycle, optional write alongside; checks result one edge later
   task automatic do_req(input logic [1:0] kind, input logic [15:0] off,
                         input logic ov, input logic [1:0] sel,
                         input logic we, input logic [1:0] wsel,
                         input logic [15:0] wbase, input string tag);
      logic [19:0] e;
      req_valid = 1'b1; req_kind = kind; req_off = off;
      ovr_valid = ov; ovr_sel = sel;
      wr_en = we; wr_sel = wsel; wr_base = wbase;
      e = exp_pa(model_base[exp_seg(kind, ov, sel)], off);
      if (we) model_base[wsel] = wbase;
      @(negedge clk);
      chk(pa_valid == 1'b1, {tag, " R7 valid"}, {19'd0, pa_valid}, 20'd1);
      chk(pa_addr == e, tag, pa_addr, e);
      last_addr = e;
      req_valid = 1'b0; wr_en = 1'b0; ovr_valid = 1'b0;
   endtask

   task automatic do_idle(input logic we, input logic [1:0] wsel,
                          input logic [15:0] wbase, input logic [1:0] junk_sel);
      req_valid = 1'b0; wr_en = we; wr_sel = wsel; wr_base = wbase;
      ovr_sel = junk_sel;
      if (we) model_base[wsel] = wbase;
      @(negedge clk);
      chk(pa_valid == 1'b0, "R7 idle valid", {19'd0, pa_valid}, 20'd0);
      chk(pa_addr == last_addr, "R7 idle hold", pa_addr, last_addr);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      model_base[0] = 16'h0000; model_base[1] = 16'hFFFF;
      model_base[2] = 16'h0000; model_base[3] = 16'h0000;
      last_addr = '0;
      void'($urandom(32'd20251));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(pa_valid == 1'b0, "R1 valid in reset", {19'd0, pa_valid}, 20'd0);
      chk(pa_addr == 20'd0, "R1 addr in reset", pa_addr, 20'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pa_valid == 1'b0, "R1 valid after reset", {19'd0, pa_valid}, 20'd0);
      // R1 reset bases observed through requests
      do_req(2'b00, 16'h0005, 1'b0, 2'b00, 1'b0, 2'b00, 16'h0, "R1 code reset");
      do_req(2'b01, 16'h1234, 1'b0, 2'b00, 1'b0, 2'b00, 16'h0, "R1 data reset");
      do_req(2'b00, 16'h0000, 1'b1, 2'b00, 1'b0, 2'b00, 16'h0, "R1 extra reset");
      // R8 wrap: FFFF0 + 0010
      do_req(2'b00, 16'h0010, 1'b0, 2'b00, 1'b0, 2'b00, 16'h0, "R8 wrap");
      do_req(2'b00, 16'hFFFF, 1'b0, 2'b00, 1'b0, 2'b00, 16'h0, "R8 wrap max");
      // R6 load distinct bases
      do_idle(1'b1, 2'b01, 16'h1000, 2'b00);
      do_idle(1'b1, 2'b11, 16'h2000, 2'b00);
      do_idle(1'b1, 2'b10, 16'h3000, 2'b00);
      do_idle(1'b1, 2'b00, 16'h4000, 2'b00);
      // R3 implicit selection
      do_req(2'b00, 16'h0011, 1'b0, 2'b00, 1'b0, 2'b00, 16'h0, "R3 fetch");
      do_req(2'b01, 16'h0022, 1'b0, 2'b00, 1'b0, 2'b00, 16'h0, "R3 data");
      do_req(2'b10, 16'h0033, 1'b0, 2'b00, 1'b0, 2'b00, 16'h0, "R3 stack");
      do_req(2'b11, 16'h0044, 1'b0, 2'b00, 1'b0, 2'b00, 16'h0, "R3 kind11");
      // R4 override each encoding
      for (int s = 0; s < 4; s++)
         do_req(2'b10, 16'h0100, 1'b1, 2'(s), 1'b0, 2'b00, 16'h0, "R4 override");
      // R5 selector ignored when flag clear
      for (int s = 0; s < 4; s++)
         do_req(2'b00, 16'h0200, 1'b0, 2'(s), 1'b0, 2'b00, 16'h0, "R5 sel ignored");
      // R6 same-cycle write uses old base, next cycle new base
      do_req(2'b01, 16'h0007, 1'b0, 2'b00, 1'b1, 2'b11, 16'hABCD, "R6 same cycle old");
      do_req(2'b01, 16'h0007, 1'b0, 2'b00, 1'b0, 2'b00, 16'h0, "R6 next cycle new");
      // R9 overlap: code and data equal
      do_idle(1'b1, 2'b01, 16'h0700, 2'b00);
      do_idle(1'b1, 2'b11, 16'h0700, 2'b00);
      do_req(2'b00, 16'h0345, 1'b0, 2'b00, 1'b0, 2'b00, 16'h0, "R9 code view");
      chk(pa_addr == 20'h07345, "R9 overlap code", pa_addr, 20'h07345);
      do_req(2'b01, 16'h0345, 1'b0, 2'b00, 1'b0, 2'b00, 16'h0, "R9 data view");
      chk(pa_addr == 20'h07345, "R9 overlap data", pa_addr, 20'h07345);
      // R2 random traffic
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] r;
         r = $urandom();
         if (r[3:0] == 4'd0)
            do_idle(r[4], r[6:5], 16'($urandom()), r[8:7]);
         else
            do_req(r[5:4], 16'($urandom()), r[6], r[8:7], r[9] & r[10],
                   r[12:11], 16'($urandom()), "R2 random");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule